// File: doc/BRIEF.md
# Byte-Paced I2C Bus Master

This block is an I2C bus master that software steers one byte at a time through three small registers. Software puts a byte in the data register, then writes the status register to ask for a START condition followed by that byte, a repeated START, or a STOP. The first byte after any START is the device address: the 7-bit address sits in bits 7:1 and the read/write flag in bit 0. Each byte takes nine SCL clocks, eight data bits and one acknowledge bit. After the ninth clock the controller sets a pending flag, can raise an interrupt, and holds SCL low. The bus stays stalled until software clears the flag. Clearing the flag starts whatever was queued: the next data byte, a repeated START, or a STOP.

Both bus lines are open drain. The block drives a line low by setting its output-enable pin and reads the resolved level on the matching input pin. The SCL frequency comes from the system clock, divided first by one of two prescalers (16 or 512) and then by a 4-bit divider plus one. A busy flag follows START and STOP conditions seen on the bus itself.

Top module: `i2cb_master`

## Requirements
- R1: After reset the control, status and data registers read 0x00, both output enables are low and irq is low.
- R2: Each SCL clock within a byte lasts P*(D+1) system clocks. P is 16 when control bit 6 is 0 and 512 when it is 1. D is control bits 3:0.
- R3: On an idle bus, a status write (offset 1) with bit 7 set, bit 5 set and bit 4 set makes SDA fall while SCL is high. The contents of the data register (offset 2) then go out MSB first, followed by one acknowledge clock.
- R4: After the ninth clock of every byte, control bit 4 (pending) sets and SCL is held low. It stays set until software writes the control register (offset 0) with bit 4 at 0. Writing bit 4 as 1 leaves it unchanged.
- R5: For each transmitted byte, the SDA level sampled on the ninth clock is stored in status bit 0 (1 means not acknowledged).
- R6: In master receive mode (status bits 7:6 = 10), the bytes after the address byte are shifted in from SDA and stored in the data register. On the ninth clock the master pulls SDA low when control bit 7 is 1 and releases it when control bit 7 is 0.
- R7: A status write with bit 7 set, bit 4 set and bit 5 clear, made while the bus is held, waits until pending is cleared. It then makes SDA rise while SCL is high, releases both lines, and leaves pending clear.
- R8: A status write with bit 5 set, made while the bus is held, produces a START without a STOP before it, followed by the next address byte.
- R9: Status bit 5 reads 1 from a START seen on the bus until a STOP seen on the bus.
- R10: irq is high exactly when pending and control bit 5 are both set, one clock later.
- R11: SDA changes while SCL is high only to form a START or a STOP.
- R12: A status write with bit 4 clear causes no bus activity and starts no queued command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register offset: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register, one clock after the address |
| irq | output | 1 | Interrupt request |
| scl_in | input | 1 | Resolved SCL line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_in | input | 1 | Resolved SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
A wrong phase or bit count in the bit sequencer shows up on the bus within the same byte. It appears either as an SDA edge while SCL is high, which a bus monitor decodes as a spurious START or STOP, or as a byte or acknowledge value that does not match the queued expectation. A pending flag that fails to stall the bus shows up after one quarter SCL period: SCL is released and an extra byte appears while software is still idle. A wrong direction or acknowledge choice in receive mode corrupts the data register and the acknowledge bit the bus monitor sees, both of which are checked at the end of every byte.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
  localparam int BYTE_W = 8;
  localparam int DIV_W  = 4;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] RA_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] RA_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] RA_DATA = 2'd2;

  typedef enum logic [2:0] {
    E_IDLE, E_START, E_RSTART, E_BYTE, E_HOLD, E_STOP
  } eng_state_e;

  typedef enum logic [1:0] {
    CMD_NONE, CMD_START, CMD_STOP
  } cmd_e;
endpackage

// File: rtl/i2cb_clkgen.sv
module i2cb_clkgen #(
  parameter int PRE_SMALL = 16,
  parameter int PRE_LARGE = 512,
  parameter int DIV_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             sel_large,
  input  logic [DIV_W-1:0] div,
  output logic             qtick
);
  // four quarter ticks make one SCL period
  localparam int Q_SMALL = PRE_SMALL / 4;
  localparam int Q_LARGE = PRE_LARGE / 4;
  localparam int CNT_W   = $clog2(Q_LARGE * (2 ** DIV_W) + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  always_comb begin
    lim = CNT_W'(((sel_large ? Q_LARGE : Q_SMALL) * (int'(div) + 1)) - 1);
  end

  assign qtick = run && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || !run || qtick) cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2cb_engine.sv
module i2cb_engine
  import i2cb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              qtick,
  input  cmd_e              cmd,
  input  logic              en,
  input  logic              pend,
  input  logic              tx_mode,
  input  logic              ack_en,
  input  logic [BYTE_W-1:0] din,
  input  logic              sda_in,
  output logic              run,
  output logic              take,
  output logic              done,
  output logic              rx,
  output logic [BYTE_W-1:0] sh,
  output logic              nack,
  output logic              scl_lo,
  output logic              sda_lo
);
  localparam logic [3:0] ACK_BIT = 4'(BYTE_W);

  eng_state_e st;
  logic [1:0] ph;
  logic [3:0] bitn;

  assign run  = (st != E_IDLE) && (st != E_HOLD);
  assign done = (st == E_BYTE) && qtick && (ph == 2'd3) && (bitn == ACK_BIT);

  always_comb begin
    take = 1'b0;
    if (en && !pend) begin
      if (st == E_IDLE && cmd != CMD_NONE) take = 1'b1;
      if (st == E_HOLD)                    take = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= E_IDLE; ph <= 2'd0; bitn <= 4'd0; rx <= 1'b0;
      sh <= '0; nack <= 1'b0; scl_lo <= 1'b0; sda_lo <= 1'b0;
    end else begin
      case (st)
        E_IDLE: if (take && cmd == CMD_START) begin
          st <= E_START; ph <= 2'd0;
        end
        E_HOLD: if (take) begin
          ph <= 2'd0;
          case (cmd)
            CMD_START: st <= E_RSTART;
            CMD_STOP:  st <= E_STOP;
            default: begin
              st <= E_BYTE; bitn <= 4'd0; rx <= !tx_mode; sh <= din;
            end
          endcase
        end
        default: if (qtick) begin
          ph <= ph + 2'd1;
          case (st)
            E_START: begin
              if (ph == 2'd0) sda_lo <= 1'b1;
              if (ph == 2'd2) scl_lo <= 1'b1;
              if (ph == 2'd3) begin
                st <= E_BYTE; bitn <= 4'd0; rx <= 1'b0; sh <= din;
              end
            end
            E_RSTART: begin
              case (ph)
                2'd0: sda_lo <= 1'b0;
                2'd1: scl_lo <= 1'b0;
                2'd2: sda_lo <= 1'b1;
                default: begin
                  scl_lo <= 1'b1; st <= E_BYTE; bitn <= 4'd0; rx <= 1'b0; sh <= din;
                end
              endcase
            end
            E_STOP: begin
              case (ph)
                2'd0: sda_lo <= 1'b1;
                2'd1: scl_lo <= 1'b0;
                2'd2: sda_lo <= 1'b0;
                default: st <= E_IDLE;
              endcase
            end
            E_BYTE: begin
              case (ph)
                2'd0: sda_lo <= (bitn == ACK_BIT) ? (rx && ack_en) : (!rx && !sh[BYTE_W-1]);
                2'd1: scl_lo <= 1'b0;
                2'd2: begin
                  if (bitn == ACK_BIT) begin
                    if (!rx) nack <= sda_in;
                  end else begin
                    sh <= {sh[BYTE_W-2:0], sda_in};
                  end
                end
                default: begin
                  scl_lo <= 1'b1;
                  if (bitn == ACK_BIT) st <= E_HOLD;
                  else                 bitn <= bitn + 4'd1;
                end
              endcase
            end
            default: ;
          endcase
        end
      endcase
    end
  end

  // R4: a stalled bus keeps SCL pulled low
  a_r4_hold_scl_low: assert property (@(posedge clk) disable iff (rst)
    (st == E_HOLD) |-> scl_lo);

  // R3: an idle engine leaves both lines released
  a_r3_idle_released: assert property (@(posedge clk) disable iff (rst)
    (st == E_IDLE) |-> (!scl_lo && !sda_lo));

  // R11: SDA moves under a released SCL only inside START or STOP sequences
  a_r11_sda_edges: assert property (@(posedge clk) disable iff (rst)
    (!scl_lo && !$past(scl_lo) && (sda_lo != $past(sda_lo)))
      |-> (st == E_START || st == E_RSTART || st == E_STOP));
endmodule

// File: rtl/i2cb_master.sv
module i2cb_master
  import i2cb_pkg::*;
#(
  parameter int PRE_SMALL = 16,
  parameter int PRE_LARGE = 512
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        irq,
  input  logic        scl_in,
  output logic        scl_oe,
  input  logic        sda_in,
  output logic        sda_oe
);
  logic             ack_en, pre_sel, ie, pend, txen, busy, nack;
  logic [DIV_W-1:0] div;
  logic [1:0]       mode;
  logic [BYTE_W-1:0] data_q, eng_sh;
  cmd_e             cmd_q;
  logic             scl_q, sda_q;
  logic             qtick, run, take, done, eng_rx;

  wire wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
  wire wr_stat = reg_wr && (reg_addr == RA_STAT);
  wire wr_data = reg_wr && (reg_addr == RA_DATA);

  i2cb_clkgen #(.PRE_SMALL(PRE_SMALL), .PRE_LARGE(PRE_LARGE), .DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .run(run), .sel_large(pre_sel), .div(div), .qtick(qtick));

  i2cb_engine u_eng (
    .clk(clk), .rst(rst), .qtick(qtick), .cmd(cmd_q), .en(txen), .pend(pend),
    .tx_mode(mode[0]), .ack_en(ack_en), .din(data_q), .sda_in(sda_in),
    .run(run), .take(take), .done(done), .rx(eng_rx), .sh(eng_sh), .nack(nack),
    .scl_lo(scl_oe), .sda_lo(sda_oe));

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_en <= 1'b0; pre_sel <= 1'b0; ie <= 1'b0; pend <= 1'b0; div <= '0;
      mode <= 2'b00; txen <= 1'b0; data_q <= '0; cmd_q <= CMD_NONE;
      busy <= 1'b0; scl_q <= 1'b1; sda_q <= 1'b1; irq <= 1'b0; reg_rdata <= '0;
    end else begin
      if (wr_ctrl) begin
        ack_en <= reg_wdata[7]; pre_sel <= reg_wdata[6]; ie <= reg_wdata[5];
        div <= reg_wdata[DIV_W-1:0];
      end
      if (done)                         pend <= 1'b1;
      else if (wr_ctrl && !reg_wdata[4]) pend <= 1'b0;

      if (wr_stat) begin
        mode <= reg_wdata[7:6];
        txen <= reg_wdata[4];
        if (reg_wdata[7] && reg_wdata[4]) cmd_q <= reg_wdata[5] ? CMD_START : CMD_STOP;
        else                              cmd_q <= CMD_NONE;
      end else if (take) begin
        cmd_q <= CMD_NONE;
      end

      if (wr_data)            data_q <= reg_wdata;
      else if (done && eng_rx) data_q <= eng_sh;

      // bus condition detection
      scl_q <= scl_in;
      sda_q <= sda_in;
      if (scl_q && scl_in && sda_q && !sda_in)      busy <= 1'b1;
      else if (scl_q && scl_in && !sda_q && sda_in) busy <= 1'b0;

      irq <= pend && ie;

      case (reg_addr)
        RA_CTRL: reg_rdata <= {ack_en, pre_sel, ie, pend, div};
        RA_STAT: reg_rdata <= {mode, busy, txen, 3'b000, nack};
        RA_DATA: reg_rdata <= data_q;
        default: reg_rdata <= '0;
      endcase
    end
  end

  // R10: an interrupt only follows a masked-in pending flag
  a_r10_irq_source: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(pend && ie));

  // R4: pending drops only through a control write with bit 4 at 0
  a_r4_pend_sticky: assert property (@(posedge clk) disable iff (rst)
    (pend && !(wr_ctrl && !reg_wdata[4])) |=> pend);
endmodule

// File: tb/i2cb_master_tb_top.sv
module i2cb_master_tb_top;
  localparam logic [6:0] SLV   = 7'h52;
  localparam logic [6:0] OTHER = 7'h1B;
  localparam logic [10:0] EV_START = {2'd1, 9'd0};
  localparam logic [10:0] EV_STOP  = {2'd2, 9'd0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq, scl_oe, sda_oe;
  logic       slv_sda = 1'b0;
  logic       scl_line, sda_line;

  assign scl_line = ~scl_oe;
  assign sda_line = ~(sda_oe | slv_sda);

  i2cb_master dut_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .scl_in(scl_line), .scl_oe(scl_oe),
    .sda_in(sda_line), .sda_oe(sda_oe));

  int n_chk = 0;
  int n_fail = 0;
  int unexpected = 0;
  logic [10:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [10:0] ev_byte(logic [7:0] b, logic a);
    return {2'd0, a, b};
  endfunction

  function automatic logic [7:0] rd_val(int n);
    return 8'h5A + 8'(n) * 8'h37;
  endfunction

  task automatic push(string tag, logic [10:0] ev);
    exp_q.push_back(ev);
    tag_q.push_back(tag);
  endtask

  task automatic observe(logic [10:0] ev);
    if (exp_q.size() == 0) begin
      n_chk++; n_fail++; unexpected++;
      $display("FAIL R11 unexpected bus event actual=%0h expected=none", ev);
    end else begin
      string t;
      logic [10:0] e;
      t = tag_q.pop_front();
      e = exp_q.pop_front();
      chk(t, ev, e);
    end
  endtask

  // bus monitor and target model
  int bitc = -1;
  logic [7:0] shr = 8'd0;
  logic ackb = 1'b1;
  logic is_addr = 1'b0, addressed = 1'b0, rd_dir = 1'b0, rd_act = 1'b0;
  int rd_cnt = 0;
  logic [7:0] rd_cur = 8'd0;
  logic p_scl = 1'b1, p_sda = 1'b1;
  int cyc = 0, t1 = 0, last_per = 0;
  logic nack_wr = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (p_scl && scl_line && p_sda && !sda_line) begin
        observe(EV_START);
        bitc = -1; is_addr = 1'b1; rd_act = 1'b0; slv_sda = 1'b0;
      end else if (p_scl && scl_line && !p_sda && sda_line) begin
        observe(EV_STOP);
        bitc = -1; addressed = 1'b0; rd_act = 1'b0; slv_sda = 1'b0;
      end else if (!p_scl && scl_line) begin
        if (bitc >= 0 && bitc < 8) shr = {shr[6:0], sda_line};
        else if (bitc == 8)        ackb = sda_line;
        if (bitc == 1) t1 = cyc;
        if (bitc == 2) last_per = cyc - t1;
      end else if (p_scl && !scl_line) begin
        bitc++;
        if (bitc >= 1 && bitc <= 7) begin
          slv_sda = rd_act & ~rd_cur[7 - bitc];
        end else if (bitc == 8) begin
          if (is_addr) begin
            addressed = (shr[7:1] == SLV); rd_dir = shr[0]; slv_sda = addressed;
          end else if (addressed && !rd_dir) begin
            slv_sda = ~nack_wr;
          end else begin
            slv_sda = 1'b0;
          end
        end else if (bitc == 9) begin
          observe(ev_byte(shr, ackb));
          if (is_addr) rd_act = addressed && rd_dir;
          else if (rd_act) begin rd_cnt++; rd_act = !ackb; end
          is_addr = 1'b0; bitc = 0;
          if (rd_act) begin rd_cur = rd_val(rd_cnt); slv_sda = ~rd_cur[7]; end
          else slv_sda = 1'b0;
        end
      end
    end
    p_scl = scl_line;
    p_sda = sda_line;
  end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_pend(string tag);
    logic [7:0] v;
    int n;
    v = 8'd0; n = 0;
    while (!v[4] && n < 20000) begin rd(2'd0, v); n++; end
    chk(tag, v[4], 1);
  endtask

  task automatic wait_free(string tag);
    logic [7:0] v;
    int n;
    v = 8'hFF; n = 0;
    while (v[5] && n < 20000) begin rd(2'd1, v); n++; end
    chk(tag, v[5], 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    rd(2'd0, v); chk("R1 control reset", v, 8'h00);
    rd(2'd1, v); chk("R1 status reset", v, 8'h00);
    rd(2'd2, v); chk("R1 data reset", v, 8'h00);
    chk("R1 scl released", scl_oe, 0);
    chk("R1 sda released", sda_oe, 0);
    chk("R1 irq low", irq, 0);

    // R12: output disabled, start request dropped
    wr(2'd1, 8'hE0);
    repeat (300) @(negedge clk);
    chk("R12 scl idle", scl_oe, 0);
    chk("R12 sda idle", sda_oe, 0);
    rd(2'd1, v); chk("R12 status no busy", v, 8'hC0);

    // R3: start and address, divider 2
    wr(2'd0, 8'hA2);
    wr(2'd2, {SLV, 1'b0});
    push("R3 start", EV_START);
    push("R3 address byte", ev_byte({SLV, 1'b0}, 1'b0));
    wr(2'd1, 8'hF0);
    wait_pend("R4 pending after address");
    repeat (2) @(negedge clk);
    chk("R10 irq raised", irq, 1);
    rd(2'd1, v); chk("R9 busy after start", v, 8'hF0);
    chk("R2 scl period small prescaler", last_per, 48);
    repeat (100) @(negedge clk);
    chk("R4 scl held low", scl_oe, 1);
    wr(2'd0, 8'hB2);
    rd(2'd0, v); chk("R4 writing one keeps pending", v, 8'hB2);

    // data byte, acknowledged
    wr(2'd2, 8'h3C);
    push("R3 data byte", ev_byte(8'h3C, 1'b0));
    wr(2'd0, 8'hA2);
    wait_pend("R4 pending after data");
    rd(2'd1, v); chk("R5 ack recorded", v, 8'hF0);

    // data byte, not acknowledged
    nack_wr = 1'b1;
    wr(2'd2, 8'h81);
    push("R5 nacked byte", ev_byte(8'h81, 1'b1));
    wr(2'd0, 8'hA2);
    wait_pend("R4 pending after nacked byte");
    rd(2'd1, v); chk("R5 nack recorded", v, 8'hF1);
    nack_wr = 1'b0;

    // R8: repeated start into receive
    wr(2'd2, {SLV, 1'b1});
    wr(2'd1, 8'hB0);
    push("R8 repeated start", EV_START);
    push("R8 read address", ev_byte({SLV, 1'b1}, 1'b0));
    wr(2'd0, 8'hA2);
    wait_pend("R8 pending after read address");
    rd(2'd1, v); chk("R8 status after repeated start", v, 8'hB0);

    push("R6 first read byte acked", ev_byte(8'h5A, 1'b0));
    wr(2'd0, 8'hA2);
    wait_pend("R6 pending after read");
    rd(2'd2, v); chk("R6 first read data", v, 8'h5A);

    push("R6 last read byte nacked", ev_byte(8'h91, 1'b1));
    wr(2'd0, 8'h22);
    wait_pend("R6 pending after last read");
    rd(2'd2, v); chk("R6 last read data", v, 8'h91);

    // R7: stop waits for the pending clear
    wr(2'd1, 8'h90);
    repeat (50) @(negedge clk);
    rd(2'd0, v); chk("R7 stop waits for clear", v[4], 1);
    chk("R7 scl held before clear", scl_oe, 1);
    push("R7 stop", EV_STOP);
    wr(2'd0, 8'h22);
    wait_free("R9 busy clears on stop");
    repeat (20) @(negedge clk);
    chk("R7 scl released", scl_oe, 0);
    chk("R7 sda released", sda_oe, 0);
    rd(2'd0, v); chk("R7 no pending after stop", v, 8'h22);
    chk("R10 irq low after stop", irq, 0);

    // large prescaler, interrupt masked, unknown address
    wr(2'd0, 8'h40);
    wr(2'd2, {OTHER, 1'b0});
    push("R2 start large prescaler", EV_START);
    push("R5 unanswered address", ev_byte({OTHER, 1'b0}, 1'b1));
    wr(2'd1, 8'hF0);
    wait_pend("R4 pending large prescaler");
    chk("R2 scl period large prescaler", last_per, 512);
    rd(2'd1, v); chk("R5 address nack", v, 8'hF1);
    repeat (3) @(negedge clk);
    chk("R10 irq masked", irq, 0);
    wr(2'd1, 8'hD0);
    push("R7 stop large prescaler", EV_STOP);
    wr(2'd0, 8'h40);
    wait_free("R9 busy clears second stop");
    repeat (20) @(negedge clk);

    chk("R11 all expected events seen", exp_q.size(), 0);
    chk("R11 no spurious conditions", unexpected, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule